// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block sets the timing of every line and every frame on a serial display link running in video mode. A configuration write port holds the horizontal sizes in pixels, the vertical sizes in lines, a pixel format and a video mode. From these values the block derives horizontal byte word counts. It then moves through each frame one segment at a time. Along the way it emits strobes for frame start, sync start and sync end, and a request for pixel payload that carries the payload word count. A downstream packet builder consumes these strobes. Lane serialization and the packet bytes themselves are outside this block.

A rising edge on the run input starts frames. While the run input stays high and the mode is not command mode, frames follow one another with no gap. Writing command mode, or dropping the run input, never cuts a frame short: the block always finishes the frame in progress. When the stop came from a switch to command mode, the block also reports completion with a one-cycle done flag. All configuration is copied into working registers at the start of each frame, so a write made during a frame takes effect on the next frame.

Top module: `vid_timing_seq`

## Requirements
- R1: The mode field (address 0, bits 1:0) is decoded as 0 = command (video idle), 1 = sync-pulse video, 2 = sync-event video, 3 = burst video. A rising edge on runReq while the mode is command starts no frame, and busy stays 0.
- R2: Each frame visits the vertical regions in the fixed order sync (vRegion 0), back porch (1), active (2), front porch (3). Each region lasts its programmed line count: addresses 5, 6, 7 and 8 hold the counts for regions 0, 1, 2 and 3. frameStart pulses in the first cycle of the frame.
- R3: In sync-pulse mode, every line begins with a one-cycle syncStart. The sync-active segment follows, lasting (hsync width × bytes per pixel − 10) cycles. A one-cycle syncEnd comes next. The sync width is at address 1.
- R4: The back-porch segment lasts (back porch × bytes per pixel − 10) cycles in sync-pulse mode. In sync-event and burst modes it lasts ((back porch + sync width) × bytes per pixel − 10) cycles. The back porch is at address 2.
- R5: The front-porch segment lasts (front porch × bytes per pixel − 12) cycles and always ends the line. The front porch is at address 3.
- R6: The pixel format field (address 0, bits 3:2) selects 2 bytes per pixel for code 0 and 3 bytes per pixel for codes 1, 2 and 3. The payload segment lasts pixWc = active width × bytes per pixel cycles. The active width is at address 4.
- R7: The segment order within a line depends on the mode. Sync-pulse: sync start, sync active, sync end, back porch, payload, front porch. Sync-event: sync start, back porch, payload, front porch. Burst: sync start, payload, back porch, front porch. syncEnd is asserted only in sync-pulse mode.
- R8: pixReq pulses for one cycle in the first payload cycle of each line in the active region, and never on other lines. pixWc is valid while pixReq is high.
- R9: After reset the block is idle, with all strobes low. A rising edge of runReq sampled at a clock edge makes the following cycle the first cycle of a frame.
- R10: When runReq is low at the end of a frame, the block goes idle after that frame completes, and vidDone stays low.
- R11: Writing command mode during a frame lets that frame run to its end in its latched mode. The block then goes idle and raises vidDone for exactly one cycle, in the first idle cycle.
- R12: Configuration writes made during a frame leave that frame unchanged and apply from the next frame onward.
- R13: A segment length that would be zero or negative lasts one cycle, and a zero line count gives one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| runReq | input | 1 | Run request; a rising edge starts, a low level stops at the end of the frame |
| busy | output | 1 | A frame is in progress |
| vRegion | output | 2 | Current vertical region (0 sync, 1 back porch, 2 active, 3 front porch) |
| frameStart | output | 1 | First cycle of a frame |
| syncStart | output | 1 | First cycle of each line |
| syncEnd | output | 1 | End of sync-active segment (sync-pulse mode only) |
| pixReq | output | 1 | Pixel payload request |
| pixWc | output | 14 | Payload word count for the current frame |
| vidDone | output | 1 | One-cycle flag: a switch to command mode has completed |

## Verification
Every output is decoded from registered state, so each result appears in the cycle after the clock edge that captured its cause. A frame begins one edge after runReq is first seen high. The next frame, or the idle state with vidDone, begins one edge after the last front-porch cycle. A configuration write is captured at its edge but only affects the next frame latch. The bench's reference model advances at each rising edge using the inputs present at that edge. It compares busy, region and all strobes on the falling edge that follows, which is where the design's registered state has settled.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [1:0] {
    MODE_CMD   = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_BURST = 2'd3
  } vidMode_e;

  typedef enum logic [1:0] {
    VR_SYNC   = 2'd0,
    VR_BACK   = 2'd1,
    VR_ACTIVE = 2'd2,
    VR_FRONT  = 2'd3
  } vRegion_e;

  typedef enum logic [2:0] {
    HS_SSTART = 3'd0,
    HS_SYNC   = 3'd1,
    HS_SEND   = 3'd2,
    HS_BACK   = 3'd3,
    HS_ACT    = 3'd4,
    HS_FRONT  = 3'd5
  } hSeg_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchFrame;
    logic     segClr;
    hSeg_e    segSel;
    logic     lineClr;
    logic     lineInc;
    vRegion_e region;
  } seqCmd_t;

endpackage

// File: rtl/vts_dp.sv
module vts_dp
  import vts_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int WC_W  = 16,
  parameter int PWC_W = 14,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [AW-1:0]    cfgAddr,
  input  logic [DW-1:0]    cfgData,
  input  seqCmd_t          cmd,
  output vidMode_e         cfgMode,
  output vidMode_e         frmMode,
  output logic             segLast,
  output logic             segFirst,
  output logic             lineLast,
  output logic [PWC_W-1:0] pixWc
);

  localparam int VR_N       = 4;
  localparam int VERT_BASE  = 5;
  localparam int DED_SYNC   = 10;
  localparam int DED_FRONT  = 12;

  vidMode_e         modeReg;
  logic [1:0]       fmtReg;
  logic [H_W-1:0]   hswReg, hbpReg, hfpReg, hactReg;
  logic [V_W-1:0]   vLast [VR_N];

  logic [WC_W-1:0]  hsaWc, hbpWc, hfpWc, actWc;
  logic [WC_W-1:0]  segCnt, segLen;
  logic [V_W-1:0]   lineCnt;
  logic             cfgUnused;

  assign cfgUnused = ^cfgData[DW-1:H_W];

  function automatic logic [WC_W-1:0] wcCalc(input logic [H_W:0] px, input logic wide,
                                             input int deduct);
    logic [WC_W-1:0] prod;
    prod = WC_W'(px) << 1;
    if (wide) prod = prod + WC_W'(px);
    return (prod > WC_W'(deduct)) ? prod - WC_W'(deduct) : WC_W'(1);
  endfunction

  // Programmed registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_CMD;
      fmtReg  <= '0;
      hswReg  <= '0;
      hbpReg  <= '0;
      hfpReg  <= '0;
      hactReg <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        AW'(0): begin
          modeReg <= vidMode_e'(cfgData[1:0]);
          fmtReg  <= cfgData[3:2];
        end
        AW'(1): hswReg  <= cfgData[H_W-1:0];
        AW'(2): hbpReg  <= cfgData[H_W-1:0];
        AW'(3): hfpReg  <= cfgData[H_W-1:0];
        AW'(4): hactReg <= cfgData[H_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfgMode = modeReg;

  // Vertical counts: one programmed and one latched register per region
  for (genvar gi = 0; gi < VR_N; gi++) begin : g_vert
    logic [V_W-1:0] vProg;
    logic [V_W-1:0] vLastQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vProg  <= '0;
        vLastQ <= '0;
      end else begin
        if (cfgWrEn && cfgAddr == AW'(VERT_BASE + gi)) vProg <= cfgData[V_W-1:0];
        if (cmd.latchFrame) vLastQ <= (vProg == '0) ? '0 : vProg - V_W'(1);
      end
    end
    assign vLast[gi] = vLastQ;
  end

  // Frame latch of derived word counts
  logic             wide;
  logic [H_W:0]     hbpPix;
  logic [WC_W-1:0]  pixProd;

  always_comb begin
    wide    = (fmtReg != 2'd0);
    hbpPix  = (modeReg == MODE_PULSE) ? {1'b0, hbpReg} : ({1'b0, hbpReg} + {1'b0, hswReg});
    pixProd = (WC_W'(hactReg) << 1) + (wide ? WC_W'(hactReg) : WC_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmMode <= MODE_CMD;
      hsaWc   <= WC_W'(1);
      hbpWc   <= WC_W'(1);
      hfpWc   <= WC_W'(1);
      actWc   <= WC_W'(1);
      pixWc   <= '0;
    end else if (cmd.latchFrame) begin
      frmMode <= modeReg;
      hsaWc   <= wcCalc({1'b0, hswReg}, wide, DED_SYNC);
      hbpWc   <= wcCalc(hbpPix, wide, DED_SYNC);
      hfpWc   <= wcCalc({1'b0, hfpReg}, wide, DED_FRONT);
      pixWc   <= PWC_W'(pixProd);
      actWc   <= (PWC_W'(pixProd) == '0) ? WC_W'(1) : WC_W'(PWC_W'(pixProd));
    end
  end

  // Segment and line counters
  always_comb begin
    case (cmd.segSel)
      HS_SYNC:  segLen = hsaWc;
      HS_BACK:  segLen = hbpWc;
      HS_ACT:   segLen = actWc;
      HS_FRONT: segLen = hfpWc;
      default:  segLen = WC_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segCnt  <= '0;
      lineCnt <= '0;
    end else begin
      segCnt <= cmd.segClr ? '0 : segCnt + WC_W'(1);
      if (cmd.lineClr)      lineCnt <= '0;
      else if (cmd.lineInc) lineCnt <= lineCnt + V_W'(1);
    end
  end

  assign segLast  = (segCnt >= segLen - WC_W'(1));
  assign segFirst = (segCnt == '0);
  assign lineLast = (lineCnt >= vLast[cmd.region]);

  // Working copy only moves on a frame latch
  assert_latch_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.latchFrame |=> $stable(frmMode) && $stable(pixWc))
    else $error("latched frame config changed mid-frame");

  // Control always closes a segment before its counter passes the length
  assert_seg_bound_R13: assert property (@(posedge clk) disable iff (!rstN)
    segCnt < segLen)
    else $error("segment counter overran its length");

endmodule

// File: rtl/vts_ctrl.sv
module vts_ctrl
  import vts_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runReq,
  input  vidMode_e cfgMode,
  input  vidMode_e frmMode,
  input  logic     segLast,
  input  logic     segFirst,
  input  logic     lineLast,
  output seqCmd_t  cmd,
  output logic     busy,
  output vRegion_e vRegion,
  output logic     frameStart,
  output logic     syncStart,
  output logic     syncEnd,
  output logic     pixReq,
  output logic     vidDone
);

  logic     running, runPrev, firstLine;
  vRegion_e region;
  hSeg_e    seg;
  logic     startEv, lineEnd, frameEnd, contFrame;

  function automatic hSeg_e nextSeg(input vidMode_e m, input hSeg_e s);
    case (s)
      HS_SSTART: return (m == MODE_PULSE) ? HS_SYNC : ((m == MODE_BURST) ? HS_ACT : HS_BACK);
      HS_SYNC:   return HS_SEND;
      HS_SEND:   return HS_BACK;
      HS_BACK:   return (m == MODE_BURST) ? HS_FRONT : HS_ACT;
      HS_ACT:    return (m == MODE_BURST) ? HS_BACK : HS_FRONT;
      default:   return HS_SSTART;
    endcase
  endfunction

  always_comb begin
    startEv   = runReq && !runPrev && (cfgMode != MODE_CMD);
    lineEnd   = running && segLast && (seg == HS_FRONT);
    frameEnd  = lineEnd && lineLast && (region == VR_FRONT);
    contFrame = runReq && (cfgMode != MODE_CMD);

    cmd.latchFrame = (!running && startEv) || (frameEnd && contFrame);
    cmd.segClr     = !running || segLast;
    cmd.segSel     = seg;
    cmd.lineClr    = !running || (lineEnd && lineLast);
    cmd.lineInc    = lineEnd && !lineLast;
    cmd.region     = region;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      runPrev   <= 1'b0;
      firstLine <= 1'b0;
      region    <= VR_SYNC;
      seg       <= HS_SSTART;
      vidDone   <= 1'b0;
    end else begin
      runPrev <= runReq;
      vidDone <= 1'b0;
      if (!running) begin
        if (startEv) begin
          running   <= 1'b1;
          region    <= VR_SYNC;
          seg       <= HS_SSTART;
          firstLine <= 1'b1;
        end
      end else if (segLast) begin
        if (seg == HS_FRONT) begin
          seg       <= HS_SSTART;
          firstLine <= 1'b0;
          if (lineLast) begin
            if (region == VR_FRONT) begin
              region <= VR_SYNC;
              if (contFrame) begin
                firstLine <= 1'b1;
              end else begin
                running <= 1'b0;
                vidDone <= (cfgMode == MODE_CMD);
              end
            end else begin
              region <= vRegion_e'(region + 2'd1);
            end
          end
        end else begin
          seg <= nextSeg(frmMode, seg);
        end
      end
    end
  end

  assign busy       = running;
  assign vRegion    = region;
  assign syncStart  = running && (seg == HS_SSTART);
  assign syncEnd    = running && (seg == HS_SEND);
  assign frameStart = syncStart && firstLine && (region == VR_SYNC);
  assign pixReq     = running && (seg == HS_ACT) && segFirst && (region == VR_ACTIVE);

  assert_end_pulse_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    syncEnd |-> frmMode == MODE_PULSE)
    else $error("sync end outside sync-pulse mode");

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> !pixReq)
    else $error("payload request longer than one cycle");

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    vidDone |-> !busy)
    else $error("done flag while busy");

  assert_start_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> frameStart)
    else $error("run began without frame start");

  assert_region_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(vRegion)) |-> (2'(vRegion) == 2'($past(vRegion)) + 2'd1))
    else $error("vertical region skipped");

endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vts_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int WC_W  = 16,
  parameter int PWC_W = 14,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [AW-1:0]    cfgAddr,
  input  logic [DW-1:0]    cfgData,
  input  logic             runReq,
  output logic             busy,
  output logic [1:0]       vRegion,
  output logic             frameStart,
  output logic             syncStart,
  output logic             syncEnd,
  output logic             pixReq,
  output logic [PWC_W-1:0] pixWc,
  output logic             vidDone
);

  seqCmd_t  cmd;
  vidMode_e cfgMode, frmMode;
  vRegion_e regionQ;
  logic     segLast, segFirst, lineLast;

  vts_dp #(
    .H_W(H_W), .V_W(V_W), .WC_W(WC_W), .PWC_W(PWC_W), .AW(AW), .DW(DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .cmd(cmd), .cfgMode(cfgMode), .frmMode(frmMode), .segLast(segLast),
    .segFirst(segFirst), .lineLast(lineLast), .pixWc(pixWc)
  );

  vts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runReq(runReq), .cfgMode(cfgMode), .frmMode(frmMode),
    .segLast(segLast), .segFirst(segFirst), .lineLast(lineLast), .cmd(cmd),
    .busy(busy), .vRegion(regionQ), .frameStart(frameStart), .syncStart(syncStart),
    .syncEnd(syncEnd), .pixReq(pixReq), .vidDone(vidDone)
  );

  assign vRegion = 2'(regionQ);

endmodule

// File: tb/vid_timing_seq_tb.sv
module vid_timing_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        runReq = 1'b0;
  logic        busy, frameStart, syncStart, syncEnd, pixReq, vidDone;
  logic [1:0]  vRegion;
  logic [13:0] pixWc;

  always #5 clk = ~clk;

  vid_timing_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .runReq(runReq), .busy(busy), .vRegion(vRegion), .frameStart(frameStart),
    .syncStart(syncStart), .syncEnd(syncEnd), .pixReq(pixReq), .pixWc(pixWc),
    .vidDone(vidDone)
  );

  typedef struct packed {
    logic       fs;
    logic       req;
    logic       se;
    logic       ss;
    logic [1:0] rg;
  } cyc_t;

  cyc_t  q[$];
  cyc_t  eRec;
  int    eBusy, eDone, mPixWc;
  bit    mRun, mPrev;
  int    sMode, sFmt, sHsw, sHbp, sHfp, sHact;
  int    sVert[4];
  int    nChk, nBad, doneSeen, cyc;
  string scen = "R9 reset";

  task automatic cmp(string sig, string rq, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", rq, scen, sig, act, exp);
    end
  endtask

  function automatic int sat1(int x);
    return (x < 1) ? 1 : x;
  endfunction

  // Reference: expand a whole frame into expected cycles
  task automatic buildFrame();
    int bpp, hsa, hbpC, hfpC, act, nseg, lines;
    int segs[6];
    cyc_t r;
    bpp    = (sFmt == 0) ? 2 : 3;
    hsa    = sat1(sHsw * bpp - 10);
    hbpC   = sat1(((sMode == 1) ? sHbp : sHbp + sHsw) * bpp - 10);
    hfpC   = sat1(sHfp * bpp - 12);
    mPixWc = (sHact * bpp) % 16384;
    act    = (mPixWc == 0) ? 1 : mPixWc;
    if (sMode == 1) begin
      segs = '{0, 1, 2, 3, 4, 5}; nseg = 6;
    end else if (sMode == 2) begin
      segs = '{0, 3, 4, 5, 0, 0}; nseg = 4;
    end else begin
      segs = '{0, 4, 3, 5, 0, 0}; nseg = 4;
    end
    for (int rg = 0; rg < 4; rg++) begin
      lines = (sVert[rg] == 0) ? 1 : sVert[rg];
      for (int ln = 0; ln < lines; ln++) begin
        for (int k = 0; k < nseg; k++) begin
          int len;
          case (segs[k])
            1: len = hsa;
            3: len = hbpC;
            4: len = act;
            5: len = hfpC;
            default: len = 1;
          endcase
          for (int c = 0; c < len; c++) begin
            r.ss  = (segs[k] == 0);
            r.se  = (segs[k] == 2);
            r.req = (segs[k] == 4) && (c == 0) && (rg == 2);
            r.fs  = (rg == 0) && (ln == 0) && (segs[k] == 0);
            r.rg  = 2'(rg);
            q.push_back(r);
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      mRun = 0; mPrev = 0; eBusy = 0; eDone = 0; eRec = '0;
      sMode = 0; sFmt = 0; sHsw = 0; sHbp = 0; sHfp = 0; sHact = 0;
      for (int i = 0; i < 4; i++) sVert[i] = 0;
    end else begin
      eDone = 0;
      if (mRun && q.size() == 0) begin
        if (runReq && sMode != 0) buildFrame();
        else begin
          mRun  = 0;
          eDone = (sMode == 0) ? 1 : 0;
        end
      end else if (!mRun) begin
        if (runReq && !mPrev && sMode != 0) begin
          buildFrame();
          mRun = 1;
        end
      end
      if (mRun) begin eRec = q.pop_front(); eBusy = 1; end
      else begin eRec = '0; eBusy = 0; end
      mPrev = runReq;
      if (cfgWrEn) begin
        case (cfgAddr)
          4'd0: begin sMode = int'(cfgData[1:0]); sFmt = int'(cfgData[3:2]); end
          4'd1: sHsw  = int'(cfgData[11:0]);
          4'd2: sHbp  = int'(cfgData[11:0]);
          4'd3: sHfp  = int'(cfgData[11:0]);
          4'd4: sHact = int'(cfgData[11:0]);
          4'd5, 4'd6, 4'd7, 4'd8: sVert[int'(cfgAddr) - 5] = int'(cfgData[11:0]);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      cmp("busy", "R9", int'(busy), eBusy);
      if (eBusy != 0) cmp("vRegion", "R2", int'(vRegion), int'(eRec.rg));
      cmp("frameStart", "R2", int'(frameStart), int'(eRec.fs));
      cmp("syncStart", "R7", int'(syncStart), int'(eRec.ss));
      cmp("syncEnd", "R3", int'(syncEnd), int'(eRec.se));
      cmp("pixReq", "R8", int'(pixReq), int'(eRec.req));
      if (eRec.req) cmp("pixWc", "R6", int'(pixWc), mPixWc);
      cmp("vidDone", "R11", int'(vidDone), eDone);
      if (vidDone) doneSeen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog [%s] act=%0d exp=%0d", scen, cyc, 150000);
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  task automatic cfgWrite(int addr, int data);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgAddr = 4'(addr);
    cfgData = 16'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mRun || busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("busy@reset", "R9", int'(busy), 0);
    cmp("syncStart@reset", "R9", int'(syncStart), 0);
    cmp("vidDone@reset", "R9", int'(vidDone), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Sync-pulse, 24-bit format: R2 R3 R7
    scen = "R2 R3 R7 pulse";
    cfgWrite(0, (3 << 2) | 1);
    cfgWrite(1, 6); cfgWrite(2, 5); cfgWrite(3, 6); cfgWrite(4, 8);
    cfgWrite(5, 2); cfgWrite(6, 2); cfgWrite(7, 3); cfgWrite(8, 2);
    @(negedge clk); runReq = 1'b1;
    repeat (600) @(negedge clk);
    scen = "R12 midframe write";
    cfgWrite(1, 7);
    repeat (400) @(negedge clk);
    scen = "R10 stop";
    doneSeen = 0;
    runReq = 1'b0;
    waitIdle();
    cmp("busy after stop", "R10", int'(busy), 0);
    cmp("vidDone count after stop", "R10", doneSeen, 0);

    // Sync-event, 16-bit format: R4 R6
    scen = "R4 R6 event";
    cfgWrite(0, (0 << 2) | 2);
    cfgWrite(1, 4); cfgWrite(2, 6); cfgWrite(3, 8); cfgWrite(4, 5);
    @(negedge clk); runReq = 1'b1;
    repeat (300) @(negedge clk);
    scen = "R11 to command";
    doneSeen = 0;
    cfgWrite(0, 0);
    waitIdle();
    cmp("vidDone count", "R11", doneSeen, 1);
    cmp("busy after switch", "R11", int'(busy), 0);
    runReq = 1'b0;

    // R1: command mode never starts
    scen = "R1 command idle";
    repeat (3) @(negedge clk);
    runReq = 1'b1;
    repeat (20) @(negedge clk);
    cmp("busy in command mode", "R1", int'(busy), 0);
    runReq = 1'b0;
    repeat (3) @(negedge clk);

    // Burst, loosely packed 18-bit: R5 R7 R8
    scen = "R5 R7 R8 burst";
    cfgWrite(0, (1 << 2) | 3);
    cfgWrite(3, 9);
    @(negedge clk); runReq = 1'b1;
    repeat (50) @(negedge clk);
    runReq = 1'b0;
    waitIdle();
    cmp("busy after burst", "R10", int'(busy), 0);

    // Floors: R13
    scen = "R13 floors";
    cfgWrite(0, (0 << 2) | 1);
    cfgWrite(1, 1); cfgWrite(2, 2); cfgWrite(3, 3); cfgWrite(4, 0);
    cfgWrite(5, 1); cfgWrite(6, 0); cfgWrite(7, 2); cfgWrite(8, 1);
    @(negedge clk); runReq = 1'b1;
    repeat (5) @(negedge clk);
    runReq = 1'b0;
    waitIdle();
    cmp("busy after floors", "R13", int'(busy), 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule